// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Filtering Sleep

This block receives asynchronous serial frames from a single data line. It samples the line on a clock enable that runs at sixteen times the bit rate. Each frame is collected in a shift register and then moved into a receive buffer. When that move happens, the block also updates a small set of status flags, may pulse an interrupt request, and drives an active-low ready-to-receive output that shows whether the receiver is waiting for a new frame.

The frame format is set in a control register: the data length (7, 8 or 9 bits, least significant bit first), the parity mode (none, even or odd) and the number of stop bits (one or two). A sleep option supports multidrop links. While sleep is on, any frame whose most significant data bit is 0 is dropped without trace. Frames with that bit set to 1 are received as usual, so a station can watch for address frames and wake only for its own address.

Software reaches the block through a small register interface. Writes are single-cycle and reads are combinational, with four addresses: control, buffer low byte, buffer high bit, and status.

Top module: `uart_sleep_rx`

## Requirements
- R1: Control register (address 0) layout: bit 0 is the enable, bits 2:1 are the length (0 = 7 bits, 1 = 8 bits, 2 = 9 bits, 3 = 8 bits), bits 4:3 are parity (0 = none, 1 = even, 2 = odd, 3 = none), bit 5 selects two stop bits, and bit 6 is sleep. Enable and sleep can be written at any time. Length, parity and stop count are written only if the enable is 0 before the write; otherwise they keep their old values and read back unchanged.
- R2: While enabled and idle, a falling edge on `rxd` starts a frame. The line is checked again on the 8th tick after that edge. If it is high there, the start is taken as a glitch: the receiver returns to idle and nothing is received.
- R3: `rts_n` is 1 while the enable is 0. It is 0 while the receiver is enabled and idle. It is 1 from the detection of a start edge until the frame is finished or rejected.
- R4: After the last stop bit is sampled, the data bits (least significant bit first, one every 16 ticks) are moved into the buffer. Address 1 reads buffer bits 7:0, and address 2 reads buffer bit 8 in bit 0. For 7-bit and 8-bit data, the unused upper buffer bits read as 0.
- R5: Moving a frame into the buffer sets receive-complete (status bit 0). `irq` is high for exactly one cycle, and only when receive-complete goes from 0 to 1.
- R6: Overrun (status bit 1) is set when a frame is moved into the buffer while receive-complete is already 1. The buffer then holds the newer frame.
- R7: Framing error (status bit 2) is set for a stored frame when any of its configured stop bits is sampled low.
- R8: Parity error (status bit 3) is set for a stored frame when its parity bit does not match the configured mode. Even parity means the data bits plus the parity bit hold an even number of ones; odd parity means an odd number.
- R9: The error summary (status bit 4) is set whenever a stored frame sets overrun, framing error or parity error, and it is then held. Reading address 1 clears receive-complete, framing error and parity error. Writing the enable as 0 clears all five flags. Overrun and summary are cleared only by that write.
- R10: With sleep on, a frame whose top data bit (bit 6, 7 or 8, depending on the length) is 0 is dropped. The buffer, all flags and `irq` stay unchanged. A frame whose top bit is 1 is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Clock enable at sixteen times the bit rate |
| rxd | input | 1 | Serial data in (asynchronous, synchronized inside) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | One-cycle receive interrupt request |
| rts_n | output | 1 | Active-low ready-to-receive |

## Verification
The checker tests several rules on every cycle:
- `rts_n` is high whenever the receiver is disabled.
- An interrupt only comes with a fresh 0-to-1 change of receive-complete.
- Overrun can only rise while receive-complete is already set.
- The summary flag covers every error flag and never drops while the enable stays on.

The directed scenarios cover what depends on serial timing and data:
- buffer contents for each data length;
- parity and stop-bit errors;
- rejection of glitches;
- frames dropped in sleep mode leaving the buffer and flags as they were;
- the configuration lock while enabled.

// File: rtl/uart_sleep_rx.sv
module uart_sleep_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       rts_n
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {IDLE, START, BITS} st_t;
  st_t st;

  logic [1:0] sync;
  logic       rx_s, rx_d;
  logic       en, sleep, two_stop;
  logic [1:0] len, par;
  logic [CW-1:0] cnt;
  logic [3:0] idx;
  logic [8:0] sh, rbuf;
  logic       par_acc, pe_hit, ferr;
  logic       rc, oe, fe, pe, sum;

  assign rx_s = sync[1];

  logic [3:0] nbits, total;
  logic       pen, samp, last, accept, ferr_f;
  logic       ctrl_wr, rd_lo;
  logic [8:0] word;

  assign nbits   = (len == 2'd0) ? 4'd7 : (len == 2'd2) ? 4'd9 : 4'd8;
  assign pen     = (par == 2'd1) || (par == 2'd2);
  assign total   = nbits + {3'b0, pen} + 4'd1 + {3'b0, two_stop};
  assign samp    = (st == BITS) && tick16 && (cnt == LAST);
  assign last    = samp && (idx == total - 4'd1);
  assign ferr_f  = ferr | ~rx_s;
  assign accept  = last && !(sleep && !sh[8]);
  assign ctrl_wr = wr_en && (addr == 2'd0);
  assign rd_lo   = rd_en && (addr == 2'd1);
  assign rts_n   = !(en && st == IDLE);

  always_comb begin
    case (len)
      2'd0:    word = {2'b0, sh[8:2]};
      2'd2:    word = sh;
      default: word = {1'b0, sh[8:1]};
    endcase
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {1'b0, sleep, two_stop, par, len, en};
      2'd1:    rdata = rbuf[7:0];
      2'd2:    rdata = {7'b0, rbuf[8]};
      default: rdata = {3'b0, sum, pe, fe, oe, rc};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      rx_d <= 1'b1;
    end else begin
      sync <= {sync[0], rxd};
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; sleep <= 1'b0; two_stop <= 1'b0;
      len <= 2'd1; par <= 2'd0;
    end else if (ctrl_wr) begin
      en    <= wdata[0];
      sleep <= wdata[6];
      if (!en) begin
        len      <= wdata[2:1];
        par      <= wdata[4:3];
        two_stop <= wdata[5];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; idx <= '0; sh <= '0;
      par_acc <= 1'b0; pe_hit <= 1'b0; ferr <= 1'b0;
    end else if (!en || (ctrl_wr && !wdata[0])) begin
      st <= IDLE;
    end else begin
      case (st)
        IDLE: if (rx_d && !rx_s) begin
          st  <= START;
          cnt <= '0;
        end
        START: if (tick16) begin
          if (cnt == MID) begin
            cnt <= '0;
            if (!rx_s) begin
              st <= BITS; idx <= '0;
              par_acc <= 1'b0; pe_hit <= 1'b0; ferr <= 1'b0;
            end else begin
              st <= IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BITS: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            cnt <= '0;
            idx <= idx + 4'd1;
            if (idx < nbits) begin
              sh      <= {rx_s, sh[8:1]};
              par_acc <= par_acc ^ rx_s;
            end else if (pen && idx == nbits) begin
              pe_hit <= (par_acc ^ rx_s) != (par == 2'd2);
            end else if (!rx_s) begin
              ferr <= 1'b1;
            end
            if (last) st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc <= 1'b0; oe <= 1'b0; fe <= 1'b0; pe <= 1'b0; sum <= 1'b0;
      rbuf <= '0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctrl_wr && !wdata[0]) begin
        rc <= 1'b0; oe <= 1'b0; fe <= 1'b0; pe <= 1'b0; sum <= 1'b0;
      end else if (accept) begin
        rbuf <= word;
        rc   <= 1'b1;
        irq  <= !rc;
        oe   <= oe | rc;
        fe   <= ferr_f;
        pe   <= pe_hit;
        sum  <= sum | rc | ferr_f | pe_hit;
      end else if (rd_lo) begin
        rc <= 1'b0; fe <= 1'b0; pe <= 1'b0;
      end
    end
  end
endmodule

module uart_sleep_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic rts_n,
  input logic irq,
  input logic rc,
  input logic oe,
  input logic fe,
  input logic pe,
  input logic sum
);
  a_r3_rts_high_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> rts_n);
  a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rc && !$past(rc)));
  a_r6_overrun_needs_rc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(rc));
  a_r9_sum_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (oe || fe || pe) |-> sum);
  a_r9_sum_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sum) && $past(en) && en) |-> sum);
endmodule

bind uart_sleep_rx uart_sleep_rx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rts_n(rts_n), .irq(irq),
  .rc(rc), .oe(oe), .fe(fe), .pe(pe), .sum(sum)
);

// File: tb/test_uart_sleep_rx.sv
module test_uart_sleep_rx;
  localparam int BT = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq, rts_n;
  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  logic [1:0] tdiv = 2'd0;
  logic rts_mid;

  uart_sleep_rx i_uart_sleep_rx (.*);

  always #10 clk = ~clk;
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd2);
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input bit e, input logic [1:0] l,
      input logic [1:0] p, input bit two, input bit slp);
    return {1'b0, slp, two, p, l, e};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic hold(input logic v);
    rxd = v;
    repeat (BT) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input int pm,
      input bit bad_par, input int stops, input bit bad_stop);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    if (pm == 2) p = ~p;
    if (bad_par) p = ~p;
    @(negedge clk);
    hold(1'b0);
    rts_mid = rts_n;
    for (int i = 0; i < nb; i++) hold(d[i]);
    if (pm != 0) hold(p);
    for (int i = 0; i < stops; i++) hold(!(bad_stop && i == stops - 1));
    hold(1'b1);
  endtask

  task automatic restart(input logic [7:0] c);
    wr(2'd0, 8'h00);
    wr(2'd0, {c[7:1], 1'b0});
    wr(2'd0, c);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R3 rts_n off after reset", 32'(rts_n), 1);
    chk("R5 irq low after reset", 32'(irq), 0);
    rd(2'd3, v); chk("R9 status clear after reset", 32'(v), 0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    wr(2'd0, cw(1, 2'd1, 2'd0, 0, 0));
    chk("R3 rts_n low when enabled idle", 32'(rts_n), 0);
    send(9'h0A5, 8, 0, 0, 1, 0);
    chk("R3 rts_n high inside frame", 32'(rts_mid), 1);
    chk("R3 rts_n low after frame", 32'(rts_n), 0);
    chk("R5 one irq pulse", 32'(irq_cnt), 1);
    rd(2'd3, v); chk("R5 rc set, no errors", 32'(v), 32'h01);
    rd(2'd1, v); chk("R4 buffer low 8-bit", 32'(v), 32'hA5);
    rd(2'd3, v); chk("R9 low read clears rc", 32'(v), 0);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    send(9'h011, 8, 0, 0, 1, 0);
    send(9'h022, 8, 0, 0, 1, 0);
    chk("R5 no irq while rc already set", 32'(irq_cnt), 2);
    rd(2'd3, v); chk("R6 overrun and summary", 32'(v), 32'h13);
    rd(2'd1, v); chk("R6 newer frame kept", 32'(v), 32'h22);
    rd(2'd3, v); chk("R9 read keeps oe and sum", 32'(v), 32'h12);
    restart(cw(1, 2'd1, 2'd0, 0, 0));
    rd(2'd3, v); chk("R9 disable clears all flags", 32'(v), 0);
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send(9'h03C, 8, 0, 0, 1, 1);
    rd(2'd3, v); chk("R7 framing error one stop", 32'(v), 32'h15);
    restart(cw(1, 2'd1, 2'd0, 1, 0));
    send(9'h0C3, 8, 0, 0, 2, 1);
    rd(2'd3, v); chk("R7 second stop low flagged", 32'(v), 32'h15);
    rd(2'd1, v);
    send(9'h0C3, 8, 0, 0, 2, 0);
    rd(2'd3, v); chk("R7 clean two-stop frame", 32'(v), 32'h11);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    restart(cw(1, 2'd1, 2'd1, 0, 0));
    send(9'h037, 8, 1, 0, 1, 0);
    rd(2'd3, v); chk("R8 even parity good", 32'(v), 32'h01);
    rd(2'd1, v); chk("R8 even data", 32'(v), 32'h37);
    send(9'h037, 8, 1, 1, 1, 0);
    rd(2'd3, v); chk("R8 even parity bad", 32'(v), 32'h19);
    restart(cw(1, 2'd1, 2'd2, 0, 0));
    send(9'h037, 8, 2, 0, 1, 0);
    rd(2'd3, v); chk("R8 odd parity good", 32'(v), 32'h01);
    rd(2'd1, v);
    send(9'h037, 8, 2, 1, 1, 0);
    rd(2'd3, v); chk("R8 odd parity bad", 32'(v), 32'h19);
  endtask

  task automatic t_lengths;
    logic [7:0] v;
    restart(cw(1, 2'd0, 2'd0, 0, 0));
    send(9'h055, 7, 0, 0, 1, 0);
    rd(2'd1, v); chk("R4 7-bit data", 32'(v), 32'h55);
    rd(2'd2, v); chk("R4 7-bit high bit zero", 32'(v), 0);
    restart(cw(1, 2'd2, 2'd0, 0, 0));
    send(9'h1A3, 9, 0, 0, 1, 0);
    rd(2'd2, v); chk("R4 9-bit high bit", 32'(v), 1);
    rd(2'd1, v); chk("R4 9-bit low byte", 32'(v), 32'hA3);
  endtask

  task automatic t_sleep;
    logic [7:0] v;
    int c0;
    restart(cw(1, 2'd1, 2'd0, 0, 1));
    send(9'h085, 8, 0, 0, 1, 0);
    rd(2'd1, v); chk("R10 address frame accepted", 32'(v), 32'h85);
    c0 = irq_cnt;
    send(9'h042, 8, 0, 0, 1, 1);
    chk("R10 dropped frame no irq", 32'(irq_cnt), 32'(c0));
    rd(2'd3, v); chk("R10 dropped frame flags untouched", 32'(v), 0);
    rd(2'd1, v); chk("R10 dropped frame buffer kept", 32'(v), 32'h85);
    restart(cw(1, 2'd0, 2'd0, 0, 1));
    send(9'h03F, 7, 0, 0, 1, 0);
    rd(2'd3, v); chk("R10 7-bit top clear dropped", 32'(v), 0);
    send(9'h041, 7, 0, 0, 1, 0);
    rd(2'd1, v); chk("R10 7-bit top set accepted", 32'(v), 32'h41);
    restart(cw(1, 2'd2, 2'd0, 0, 1));
    send(9'h0FF, 9, 0, 0, 1, 0);
    rd(2'd3, v); chk("R10 9-bit top clear dropped", 32'(v), 0);
    wr(2'd0, cw(1, 2'd2, 2'd0, 0, 0));
    send(9'h0FF, 9, 0, 0, 1, 0);
    rd(2'd1, v); chk("R10 sleep off receives all", 32'(v), 32'hFF);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    int c0;
    restart(cw(1, 2'd1, 2'd0, 0, 0));
    c0 = irq_cnt;
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (20 * BT) @(negedge clk);
    rd(2'd3, v); chk("R2 glitch rejected", 32'(v), 0);
    chk("R2 glitch no irq", 32'(irq_cnt), 32'(c0));
    chk("R3 rts_n low after glitch", 32'(rts_n), 0);
  endtask

  task automatic t_cfg_lock;
    logic [7:0] v;
    wr(2'd0, cw(1, 2'd2, 2'd1, 1, 0));
    rd(2'd0, v); chk("R1 config locked while enabled", 32'(v), 32'(cw(1, 2'd1, 2'd0, 0, 0)));
    send(9'h03C, 8, 0, 0, 1, 0);
    rd(2'd3, v); chk("R1 old format still used", 32'(v), 32'h01);
    rd(2'd1, v); chk("R1 old format data", 32'(v), 32'h3C);
    wr(2'd0, 8'h00);
    chk("R3 rts_n high after disable", 32'(rts_n), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_basic;
    t_overrun;
    t_framing;
    t_parity;
    t_lengths;
    t_sleep;
    t_glitch;
    t_cfg_lock;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule